// File: doc/BRIEF.md
# Load/Store to AHB-Lite Master Bridge

This block lets a simple load/store client drive an AHB-Lite master port that sits behind an external arbiter. The client presents an address, write data, a load or store strobe, a transfer size, a burst type and a transfer type. The bridge raises a bus request. Once the arbiter grants the bus and the bus is ready, it launches the address phase. While it holds the grant, it follows the client's transfer type from beat to beat. A sequential beat steps the address by the byte count of the transfer size.

Read data, the ready indication and the response pass straight from the bus back to the client. The write data for a data phase comes from the client in the cycle after the matching address phase. If the slave stalls that data phase, the bridge freezes the value it saw in the first stalled cycle. It keeps that value on the bus until the phase completes, whatever the client does in the meantime. When the grant is withdrawn at a completed cycle, the bridge drops to an idle transfer and waits for a new grant.

Top module: `ls_ahb_master`

## Requirements
- R1: `bus_req` is high exactly when `usr_load` or `usr_store` is high, in the same cycle.
- R2: While waiting, a clock edge with `bus_gnt`, `hready` and a load or store request all high loads `haddr`, `htrans`, `hsize` and `hburst` from the client, and sets `hwrite` to `usr_store`. Without all three, `htrans` stays IDLE (2'b00).
- R3: While running with grant and `hready` high, a client transfer type of SEQ (2'b11) makes the next `haddr` equal the current one plus (1 << `hsize`), and `htrans` becomes SEQ.
- R4: While running with `hready` low, `haddr`, `htrans`, `hwrite`, `hsize` and `hburst` keep their values.
- R5: While running, an edge with `hready` high and `bus_gnt` low sets `htrans` to IDLE and returns to waiting. A later start again needs the grant.
- R6: In a write data phase stalled by `hready` low, `hwdata` keeps the client value from the first stalled cycle until the cycle in which `hready` is high. After that cycle, `hwdata` follows `usr_wdata` again.
- R7: `usr_ready`, `usr_resp` and `usr_rdata` equal `hready`, `hresp` and `hrdata` in the same cycle.
- R8: An active-low `rst_n` clears asynchronously: `htrans` IDLE, `haddr` 0, `hwrite` 0, and any held write data released so that `hwdata` follows `usr_wdata`.
- R9: While running with grant and `hready` high, client type BUSY (2'b01) keeps `haddr` and drives `htrans` BUSY. Type IDLE drives `htrans` IDLE. Type NONSEQ (2'b10) loads a fresh address and controls from the client.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_addr | input | AW | Client address |
| usr_wdata | input | DW | Client write data for the current data phase |
| usr_load | input | 1 | Client read request |
| usr_store | input | 1 | Client write request |
| usr_size | input | 3 | Transfer size, bytes = 1 << size |
| usr_burst | input | 3 | Burst type passed to the bus |
| usr_trans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| usr_ready | output | 1 | Bus ready seen by the client |
| usr_rdata | output | DW | Read data seen by the client |
| usr_resp | output | 1 | Bus response seen by the client |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus write direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst type |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response |

## Verification
A table of load/store, ready, response and read-data combinations first separates the combinational request and return paths from the registered state. Directed sequences then start a word burst and step it with SEQ, BUSY and NONSEQ beats. They insert a multi-cycle write stall while the client changes its data, which tells a frozen data phase apart from a live one. A byte-size burst confirms that the step follows `hsize`. Withholding the grant or ready before a start, withdrawing the grant mid-run, and resetting during a held write separate the start conditions, the return to waiting, and the clearing of the hold.

// File: rtl/ls_ahb_pkg.sv
package ls_ahb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } tr_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    localparam int SIZE_W  = 3;
    localparam int BURST_W = 3;

endpackage

// File: rtl/ls_ahb_addr_step.sv
module ls_ahb_addr_step #(
    parameter int AW     = 32,
    parameter int SIZE_W = 3
) (
    input  logic [AW-1:0]     cur_addr,
    input  logic [SIZE_W-1:0] size,
    output logic [AW-1:0]     next_addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] stride;

    always_comb begin
        stride    = ONE << size;
        next_addr = cur_addr + stride;
    end
endmodule

// File: rtl/ls_ahb_ctrl.sv
module ls_ahb_ctrl
    import ls_ahb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_gnt,
    input  logic                hready,
    input  logic                usr_load,
    input  logic                usr_store,
    input  logic [AW-1:0]       usr_addr,
    input  logic [SIZE_W-1:0]   usr_size,
    input  logic [BURST_W-1:0]  usr_burst,
    input  logic [1:0]          usr_trans,
    output logic [AW-1:0]       haddr,
    output logic [1:0]          htrans,
    output logic                hwrite,
    output logic [SIZE_W-1:0]   hsize,
    output logic [BURST_W-1:0]  hburst
);
    typedef struct packed {
        st_e                st;
        logic [AW-1:0]      addr;
        logic [1:0]         trans;
        logic               wr;
        logic [SIZE_W-1:0]  size;
        logic [BURST_W-1:0] burst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [AW-1:0] step_addr;
    logic          want;

    ls_ahb_addr_step #(.AW(AW), .SIZE_W(SIZE_W)) u_step (
        .cur_addr  (ctl_q.addr),
        .size      (ctl_q.size),
        .next_addr (step_addr)
    );

    assign want = usr_load | usr_store;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_WAIT: begin
                ctl_d.trans = TR_IDLE;
                if (bus_gnt && hready && want) begin
                    ctl_d.st    = ST_RUN;
                    ctl_d.addr  = usr_addr;
                    ctl_d.trans = usr_trans;
                    ctl_d.wr    = usr_store;
                    ctl_d.size  = usr_size;
                    ctl_d.burst = usr_burst;
                end
            end
            ST_RUN: begin
                if (hready) begin
                    if (!bus_gnt) begin
                        ctl_d.st    = ST_WAIT;
                        ctl_d.trans = TR_IDLE;
                    end else begin
                        case (usr_trans)
                            TR_NSEQ: begin
                                ctl_d.addr  = usr_addr;
                                ctl_d.trans = TR_NSEQ;
                                ctl_d.wr    = usr_store;
                                ctl_d.size  = usr_size;
                                ctl_d.burst = usr_burst;
                            end
                            TR_SEQ: begin
                                ctl_d.addr  = step_addr;
                                ctl_d.trans = TR_SEQ;
                            end
                            TR_BUSY: ctl_d.trans = TR_BUSY;
                            default: ctl_d.trans = TR_IDLE;
                        endcase
                    end
                end
            end
            default: ctl_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_WAIT, addr: '0, trans: TR_IDLE, wr: 1'b0,
                       size: '0, burst: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign haddr  = ctl_q.addr;
    assign htrans = ctl_q.trans;
    assign hwrite = ctl_q.wr;
    assign hsize  = ctl_q.size;
    assign hburst = ctl_q.burst;

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && !(bus_gnt && hready && want)) |=> htrans == TR_IDLE);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && hready && bus_gnt && usr_trans == TR_SEQ)
        |=> (haddr == $past(haddr) + (AW'(1) << $past(hsize))) && htrans == TR_SEQ);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && !hready)
        |=> $stable(haddr) && $stable(htrans) && $stable(hwrite) && $stable(hsize) && $stable(hburst));

    // R5
    gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && hready && !bus_gnt) |=> htrans == TR_IDLE);
endmodule

// File: rtl/ls_ahb_wdata.sv
module ls_ahb_wdata #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic [1:0]    htrans,
    input  logic          hwrite,
    input  logic [DW-1:0] usr_wdata,
    output logic [DW-1:0] hwdata
);
    typedef struct packed {
        logic          dwr;
        logic          held;
        logic [DW-1:0] data;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (hready) begin
            wd_d.dwr  = hwrite & htrans[1];
            wd_d.held = 1'b0;
        end else if (wd_q.dwr && !wd_q.held) begin
            wd_d.held = 1'b1;
            wd_d.data = usr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '{dwr: 1'b0, held: 1'b0, data: '0};
        end else begin
            wd_q <= wd_d;
        end
    end

    assign hwdata = wd_q.held ? wd_q.data : usr_wdata;

    // R6
    wdata_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.dwr && !hready) ##1 !hready |-> $stable(hwdata));

    // R6
    hold_in_wphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.held |-> wd_q.dwr);
endmodule

// File: rtl/ls_ahb_master.sv
module ls_ahb_master
    import ls_ahb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       usr_addr,
    input  logic [DW-1:0]       usr_wdata,
    input  logic                usr_load,
    input  logic                usr_store,
    input  logic [2:0]          usr_size,
    input  logic [2:0]          usr_burst,
    input  logic [1:0]          usr_trans,
    output logic                usr_ready,
    output logic [DW-1:0]       usr_rdata,
    output logic                usr_resp,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic [AW-1:0]       haddr,
    output logic [1:0]          htrans,
    output logic                hwrite,
    output logic [2:0]          hsize,
    output logic [2:0]          hburst,
    output logic [DW-1:0]       hwdata,
    input  logic [DW-1:0]       hrdata,
    input  logic                hready,
    input  logic                hresp
);
    ls_ahb_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .hready    (hready),
        .usr_load  (usr_load),
        .usr_store (usr_store),
        .usr_addr  (usr_addr),
        .usr_size  (usr_size),
        .usr_burst (usr_burst),
        .usr_trans (usr_trans),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hburst    (hburst)
    );

    ls_ahb_wdata #(.DW(DW)) u_wdata (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .usr_wdata (usr_wdata),
        .hwdata    (hwdata)
    );

    assign bus_req   = usr_load | usr_store;
    assign usr_ready = hready;
    assign usr_resp  = hresp;
    assign usr_rdata = hrdata;
endmodule

// File: tb/ls_ahb_master_tb.sv
module ls_ahb_master_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic          usr_load = 1'b0, usr_store = 1'b0;
    logic [2:0]    usr_size = '0, usr_burst = '0;
    logic [1:0]    usr_trans = 2'b00;
    logic          usr_ready, usr_resp, bus_req;
    logic [DW-1:0] usr_rdata, hwdata;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic          hwrite;
    logic [2:0]    hsize, hburst;
    logic [DW-1:0] hrdata = '0;
    logic          hready = 1'b1, hresp = 1'b0;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ls_ahb_master #(.AW(AW), .DW(DW)) u_dut (.*);

    // {load, store, hready, hresp, rdata}
    localparam logic [35:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
        {1'b1, 1'b0, 1'b1, 1'b0, 32'h1234_5678},
        {1'b0, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 1'b0, 1'b1, 32'h0F0F_0F0F},
        {1'b1, 1'b0, 1'b1, 1'b1, 32'hA5A5_5A5A}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        #3;
        chk("R8 htrans", 64'(htrans), 64'h0);
        chk("R8 haddr", 64'(haddr), 64'h0);
        chk("R8 hwrite", 64'(hwrite), 64'h0);
        usr_wdata = 32'h0BAD_F00D;
        #1;
        chk("R8 hwdata", 64'(hwdata), 64'h0BAD_F00D);
        tick();
        rst_n = 1'b1;
        tick();

        // R1 R7 vector walk, grant held low
        for (int i = 0; i < 6; i++) begin
            {usr_load, usr_store, hready, hresp, hrdata} = VEC[i];
            #1;
            chk("R1 bus_req", 64'(bus_req), 64'(VEC[i][35] | VEC[i][34]));
            chk("R7 usr_ready", 64'(usr_ready), 64'(VEC[i][33]));
            chk("R7 usr_resp", 64'(usr_resp), 64'(VEC[i][32]));
            chk("R7 usr_rdata", 64'(usr_rdata), 64'(VEC[i][31:0]));
            tick();
        end

        // R2 no start without grant, or without ready
        usr_load = 1'b1; usr_store = 1'b0; usr_addr = 32'h100;
        usr_trans = 2'b10; hready = 1'b1; bus_gnt = 1'b0;
        tick();
        chk("R2 no grant", 64'(htrans), 64'h0);
        bus_gnt = 1'b1; hready = 1'b0;
        tick();
        chk("R2 no ready", 64'(htrans), 64'h0);

        // R2 start: word write burst
        hready = 1'b1; usr_load = 1'b0; usr_store = 1'b1;
        usr_addr = 32'h1000; usr_size = 3'd2; usr_burst = 3'd3; usr_trans = 2'b10;
        tick();
        chk("R2 haddr", 64'(haddr), 64'h1000);
        chk("R2 htrans", 64'(htrans), 64'h2);
        chk("R2 hwrite", 64'(hwrite), 64'h1);
        chk("R2 hsize", 64'(hsize), 64'h2);
        chk("R2 hburst", 64'(hburst), 64'h3);
        usr_trans = 2'b11; usr_wdata = 32'hA1;
        tick();
        chk("R3 step word", 64'(haddr), 64'h1004);
        chk("R3 seq", 64'(htrans), 64'h3);

        // R6 stall during write data phase
        hready = 1'b0; usr_wdata = 32'hA2;
        #1;
        chk("R6 live", 64'(hwdata), 64'hA2);
        tick();
        chk("R4 hold addr", 64'(haddr), 64'h1004);
        usr_wdata = 32'hBEEF;
        #1;
        chk("R6 frozen", 64'(hwdata), 64'hA2);
        tick();
        chk("R4 hold trans", 64'(htrans), 64'h3);
        chk("R6 frozen2", 64'(hwdata), 64'hA2);
        hready = 1'b1;
        #1;
        chk("R6 completing", 64'(hwdata), 64'hA2);
        tick();
        chk("R3 after stall", 64'(haddr), 64'h1008);
        chk("R6 released", 64'(hwdata), 64'hBEEF);

        // R9 BUSY, then SEQ, then NONSEQ
        usr_trans = 2'b01;
        tick();
        chk("R9 busy addr", 64'(haddr), 64'h1008);
        chk("R9 busy trans", 64'(htrans), 64'h1);
        usr_trans = 2'b11;
        tick();
        chk("R3 after busy", 64'(haddr), 64'h100C);
        usr_trans = 2'b10; usr_addr = 32'h2000; usr_store = 1'b0; usr_load = 1'b1;
        usr_size = 3'd0; usr_burst = 3'd1;
        tick();
        chk("R9 nonseq addr", 64'(haddr), 64'h2000);
        chk("R9 nonseq write", 64'(hwrite), 64'h0);
        usr_trans = 2'b11;
        tick();
        chk("R3 byte step", 64'(haddr), 64'h2001);

        // R5 grant withdrawn
        bus_gnt = 1'b0;
        tick();
        chk("R5 idle", 64'(htrans), 64'h0);
        usr_trans = 2'b10; usr_addr = 32'h2800;
        tick();
        chk("R5 waits for grant", 64'(htrans), 64'h0);
        bus_gnt = 1'b1;
        tick();
        chk("R5 restart", 64'(haddr), 64'h2800);

        // R9 IDLE type while running
        usr_trans = 2'b00;
        tick();
        chk("R9 idle type", 64'(htrans), 64'h0);
        chk("R9 idle addr", 64'(haddr), 64'h2800);

        // R8 reset during a held write
        usr_trans = 2'b10; usr_addr = 32'h4000; usr_store = 1'b1; usr_load = 1'b0;
        tick();
        tick();
        hready = 1'b0; usr_wdata = 32'h55;
        tick();
        usr_wdata = 32'h66;
        #1;
        chk("R6 held 55", 64'(hwdata), 64'h55);
        rst_n = 1'b0;
        #1;
        chk("R8 release hold", 64'(hwdata), 64'h66);
        chk("R8 htrans", 64'(htrans), 64'h0);
        chk("R8 haddr", 64'(haddr), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule